// File: doc/BRIEF.md
# Priority-Select Load Register

A single register word that can be loaded from any one of several parallel sources. Each source supplies one data word and one request bit. At a clock edge, if any request bit is set, the register takes the word of the lowest-numbered requesting source. If no request bit is set, the register keeps the value it already holds. The source count and the word width are parameters. The priority scan is a single loop, so the register has exactly one driver whatever the source count.

The block sits wherever several producers can update one shared value in the same cycle and a fixed order settles who wins. The output comes straight from the flop, so requests and data that change between edges never reach the output until the next edge. Reset clears the word at once. Reset release passes through a two-stage synchronizer, so the register only begins to load on the third clock edge after the reset input rises.

Top module: `prio_load_reg`

## Requirements
- R1: While `rst_n` is low, `q_o` is zero, and it goes to zero without waiting for a clock edge.
- R2: After `rst_n` rises, `q_o` stays zero across the first two rising clock edges whatever the requests. The first load can happen at the third edge.
- R3: If exactly one bit k of `en_i` is set at a rising edge, `q_o` then equals source word k. Source word k is `data_i[k*W_DATA +: W_DATA]`. This holds for every k from 0 to N_SRC-1, including the top index.
- R4: If several bits of `en_i` are set at a rising edge, `q_o` takes the word of the lowest set bit index. Bit 0 has the highest priority.
- R5: If `en_i` is all zeros at a rising edge, `q_o` keeps its previous value, whatever `data_i` holds.
- R6: Changes of `en_i` or `data_i` between rising edges leave `q_o` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all loads happen on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchronizer |
| en_i | input | N_SRC | Load request per source; bit 0 has the highest priority |
| data_i | input | N_SRC*W_DATA | Source words packed side by side; word k occupies bits k*W_DATA and up |
| q_o | output | W_DATA | Registered value |

## Verification
The bench walks every one-hot request pattern, each with two different data fills, so that any source index that is misrouted or unreachable shows up as a wrong word. The all-zero request pattern is applied while the data keeps changing, which separates a true hold from a load of some default source. Several hundred random multi-hot patterns are run against a lowest-set-bit model, which catches reversed or broken priority. Mid-cycle input changes and the reset release sequence confirm that the output is purely registered and that loading starts on the stated edge.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int unsigned PLS_DEF_SRC   = 8;
  localparam int unsigned PLS_DEF_WIDTH = 8;
  localparam int unsigned PLS_SYNC_DEPTH = 2;
endpackage

// File: rtl/pls_rst_sync.sv
module pls_rst_sync #(
  parameter int unsigned DEPTH = pls_pkg::PLS_SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_q
);
  logic [DEPTH-1:0] chain_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_r <= '0;
    else        chain_r <= {chain_r[DEPTH-2:0], 1'b1};
  end

  assign rst_n_q = chain_r[DEPTH-1];
endmodule

// File: rtl/pls_scan.sv
module pls_scan #(
  parameter int unsigned N_SRC = pls_pkg::PLS_DEF_SRC
) (
  input  logic [N_SRC-1:0] req,
  output logic [N_SRC-1:0] grant,
  output logic             hit
);
  localparam int TOP = int'(N_SRC) - 1;

  always_comb begin
    grant = '0;
    hit   = 1'b0;
    for (int i = TOP; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        hit      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pls_mux.sv
module pls_mux #(
  parameter int unsigned N_SRC  = pls_pkg::PLS_DEF_SRC,
  parameter int unsigned W_DATA = pls_pkg::PLS_DEF_WIDTH
) (
  input  logic [N_SRC-1:0]        grant,
  input  logic [N_SRC*W_DATA-1:0] words,
  output logic [W_DATA-1:0]       sel
);
  always_comb begin
    sel = '0;
    for (int i = 0; i < int'(N_SRC); i++) begin
      sel = sel | (words[i*W_DATA +: W_DATA] & {W_DATA{grant[i]}});
    end
  end
endmodule

// File: rtl/prio_load_reg.sv
module prio_load_reg #(
  parameter int unsigned N_SRC  = pls_pkg::PLS_DEF_SRC,
  parameter int unsigned W_DATA = pls_pkg::PLS_DEF_WIDTH
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        en_i,
  input  logic [N_SRC*W_DATA-1:0] data_i,
  output logic [W_DATA-1:0]       q_o
);
  logic              rst_n_q;
  logic [N_SRC-1:0]  grant_w;
  logic              load_w;
  logic [W_DATA-1:0] d_nxt;
  logic [W_DATA-1:0] q_r;

  pls_rst_sync #(.DEPTH(pls_pkg::PLS_SYNC_DEPTH)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_n_q(rst_n_q)
  );

  pls_scan #(.N_SRC(N_SRC)) u_scan (
    .req(en_i), .grant(grant_w), .hit(load_w)
  );

  pls_mux #(.N_SRC(N_SRC), .W_DATA(W_DATA)) u_mux (
    .grant(grant_w), .words(data_i), .sel(d_nxt)
  );

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q)    q_r <= '0;
    else if (load_w) q_r <= d_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/pls_chk.sv
module pls_chk #(
  parameter int unsigned N_SRC  = pls_pkg::PLS_DEF_SRC,
  parameter int unsigned W_DATA = pls_pkg::PLS_DEF_WIDTH
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rst_n_q,
  input logic [N_SRC-1:0]        en_i,
  input logic [N_SRC*W_DATA-1:0] data_i,
  input logic [N_SRC-1:0]        grant,
  input logic [W_DATA-1:0]       q_o
);
  localparam logic [N_SRC-1:0] TOP_ONLY = {1'b1, {(N_SRC-1){1'b0}}};

  a_r1_reset_zero: assert property (@(posedge clk) !rst_n |-> q_o == '0);

  a_r2_release_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_n_q |=> q_o == '0);

  a_r3_top_source: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n_q && en_i == TOP_ONLY) |=> q_o == $past(data_i[(N_SRC-1)*W_DATA +: W_DATA]));

  a_r4_bit0_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n_q && en_i[0]) |=> q_o == $past(data_i[W_DATA-1:0]));

  a_r4_grant_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~en_i) == '0) && ((en_i != '0) == (grant != '0)));

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n_q && en_i == '0) |=> $stable(q_o));
endmodule

bind prio_load_reg pls_chk #(.N_SRC(N_SRC), .W_DATA(W_DATA)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_n_q(rst_n_q), .en_i(en_i),
  .data_i(data_i), .grant(grant_w), .q_o(q_o)
);

// File: tb/prio_load_reg_bench.sv
module prio_load_reg_bench;
  localparam int N = 8;
  localparam int W = 8;

  logic           clk;
  logic           rst_n;
  logic [N-1:0]   en;
  logic [N*W-1:0] data;
  logic [W-1:0]   q;
  logic [W-1:0]   q_exp;
  int             n_vec;
  int             n_bad;
  bit             done;

  prio_load_reg #(.N_SRC(N), .W_DATA(W)) u_prio_load_reg (
    .clk(clk), .rst_n(rst_n), .en_i(en), .data_i(data), .q_o(q)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [W-1:0] model(logic [N-1:0] e, logic [N*W-1:0] d,
                                         logic [W-1:0] cur);
    for (int i = 0; i < N; i++)
      if (e[i]) return d[i*W +: W];
    return cur;
  endfunction

  task automatic check(string tag, logic [W-1:0] exp);
    n_vec++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%h expected %h", tag, q, exp);
    end
  endtask

  task automatic fill_random();
    for (int i = 0; i < N; i++) data[i*W +: W] = W'($urandom);
  endtask

  // drive at negedge, let a rising edge pass, sample 1 ns later
  task automatic step(string tag);
    @(negedge clk);
    q_exp = model(en, data, q_exp);
    @(posedge clk);
    #1;
    check(tag, q_exp);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: q=%h expected finish", q);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b1; en = '0; data = '0; q_exp = '0;
    #1 rst_n = 1'b0;
    fill_random();
    en = '1;
    #1 check("R1 async clear", '0);
    repeat (3) @(posedge clk);
    #1 check("R1 held in reset", '0);

    // R2: release between edges, two edges without load
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1 check("R2 edge1", '0);
    @(posedge clk); #1 check("R2 edge2", '0);
    @(posedge clk); #1 check("R2 edge3 load", data[W-1:0]);
    q_exp = data[W-1:0];

    // R3: every single-hot pattern with two fills
    for (int f = 0; f < 2; f++) begin
      for (int k = 0; k < N; k++) begin
        @(negedge clk);
        fill_random();
        if (f == 1) for (int i = 0; i < N; i++) data[i*W +: W] = W'(8'hA0 + i);
        en = N'(1) << k;
        step("R3 single-hot");
      end
    end

    // R5: idle pattern with moving data
    for (int r = 0; r < 10; r++) begin
      @(negedge clk);
      en = '0;
      fill_random();
      step("R5 idle hold");
    end

    // R4: random multi-hot patterns
    for (int r = 0; r < 400; r++) begin
      @(negedge clk);
      fill_random();
      en = N'($urandom);
      if ($countones(en) < 2) en = en | N'(1) << ($urandom % N) | (N'(1) << (N-1));
      step("R4 multi-hot");
    end
    @(negedge clk);
    en = '1; fill_random();
    step("R4 all enables");

    // R6: mid-cycle changes do not reach the output
    for (int r = 0; r < 6; r++) begin
      @(negedge clk);
      en = N'($urandom) | N'(1);
      fill_random();
      #1 check("R6 mid-cycle", q_exp);
      q_exp = model(en, data, q_exp);
      @(posedge clk); #1 check("R6 after edge", q_exp);
    end

    // R1: asynchronous clear mid-cycle
    @(negedge clk);
    rst_n = 1'b0;
    #0.5 check("R1 mid-cycle clear", '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule